// File: doc/BRIEF.md
# Bit-Vector Edit Distance Search Engine

This block searches a word list held in external byte-addressed memory for the entry closest to a search pattern, measured as Levenshtein edit distance. The pattern is not sent to the block as characters. Software instead stores one 16-bit match vector per possible character code in a vector table in memory. Bit i of a character's vector is set when pattern position i holds that character. Software then writes the pattern length and starts the engine.

The engine walks the word list one byte at a time through a read-only memory request port. For every word character it fetches that character's match vector. It then advances a bit-parallel distance recurrence by one step. It does not build a dynamic-programming matrix. When a word ends, its score is compared with the best score found so far, and only the winning word index and its distance are kept. A small register port starts a search, shows when the search is running, and returns the result.

The request port follows valid/ready rules. While `mem_req_valid` is high and `mem_req_ready` is low, the engine holds the address unchanged. A request is accepted on a cycle where both are high. At most one read is outstanding at a time. The engine raises `mem_rsp_ready` only while it waits for that read, and takes the data on a cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high. Memory may stall both the request and the response for any number of cycles.

Top module: `lev_search_top`

## Requirements
- R1: After reset, the control register (0x0) reads 0x00, the index registers (0x4, 0x5) read 0x00, and the distance register (0x6) reads 0xFF.
- R2: Register 0x2 stores the pattern length minus one, and valid lengths are 1 to 16. Register 0x3 always reads 15, the largest supported length minus one.
- R3: Writing a value with bit 0 set to register 0x0 while idle starts a search. Bit 0 then reads 1 until the search ends, when the engine clears it. Writing with bit 0 clear starts nothing and issues no memory request. While idle, `mem_req_valid` stays low.
- R4: For a word character with code c, the engine reads address 0x200 + 2c to get the upper 8 bits of the match vector. It then reads address 0x200 + 2c + 1 to get the lower 8 bits.
- R5: The word list is read one byte at a time at rising addresses starting at 0x400. Byte 0x00 ends a word, and byte 0x01 ends the list. No request falls outside the vector table (0x200 to 0x3FF) or below the word list.
- R6: When a search ends, the distance register holds the smallest Levenshtein distance between the pattern and any word in the list. This holds for pattern lengths 1 through 16.
- R7: The best word has the lowest distance, and among equal distances the earliest word wins. While a search runs, the distance register never increases.
- R8: The word index counts from 0 in list order. It reads as 16 bits, with the upper byte at 0x4 and the lower byte at 0x5.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged address on the next cycle.
- R10: An empty word (a 0x00 byte directly following a word end or the list start) counts as a word, and its distance equals the pattern length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 23 | Byte address of read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waiting for read data |
| mem_rsp_data | input | 8 | Read data byte |

## Verification
The assertions check the following on every cycle:
- a stalled request stays in place with the same address;
- no request is issued while idle;
- every address falls inside the vector table or the word list;
- the best distance never rises during a search.

The correctness of the recurrence can only be shown by the bench's scenarios, which compare against a matrix-based reference distance. The same holds for tie ordering, empty words, the pattern-length boundaries of 1 and 16, and an index above 255.

// File: rtl/lev_pkg.sv
package lev_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ_CH,
    S_WAIT_CH,
    S_REQ_HI,
    S_WAIT_HI,
    S_REQ_LO,
    S_WAIT_LO
  } fetch_st_e;

  localparam logic [7:0] WORD_END_BYTE = 8'h00;
  localparam logic [7:0] LIST_END_BYTE = 8'h01;
endpackage

// File: rtl/lev_bv_core.sv
module lev_bv_core #(
  parameter int VEC_W   = 16,
  parameter int SCORE_W = 8,
  localparam int LW     = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               step,
  input  logic [VEC_W-1:0]   eq,
  input  logic [LW-1:0]      len_m1,
  output logic [SCORE_W-1:0] score
);
  logic [VEC_W-1:0] vp, vn, x, d0, hp, hn, xh, vp_n, vn_n;

  // one column of the bit-parallel recurrence
  always_comb begin
    x    = eq | vn;
    d0   = (((x & vp) + vp) ^ vp) | x;
    hp   = vn | ~(d0 | vp);
    hn   = vp & d0;
    xh   = {hp[VEC_W-2:0], 1'b1};
    vn_n = xh & d0;
    vp_n = {hn[VEC_W-2:0], 1'b0} | ~(xh | d0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp    <= '1;
      vn    <= '0;
      score <= '0;
    end else if (init) begin
      vp    <= '1;
      vn    <= '0;
      score <= SCORE_W'(len_m1) + SCORE_W'(1);
    end else if (step) begin
      vp    <= vp_n;
      vn    <= vn_n;
      score <= score + SCORE_W'(hp[len_m1]) - SCORE_W'(hn[len_m1]);
    end
  end
endmodule

// File: rtl/lev_best_track.sv
module lev_best_track #(
  parameter int IDX_W   = 16,
  parameter int SCORE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               word_end,
  input  logic [SCORE_W-1:0] score,
  output logic [IDX_W-1:0]   best_idx,
  output logic [SCORE_W-1:0] best_dist
);
  logic [IDX_W-1:0] cur_idx;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      cur_idx   <= '0;
      best_idx  <= '0;
      best_dist <= '1;
    end else if (word_end) begin
      cur_idx <= cur_idx + IDX_W'(1);
      if (score < best_dist) begin   // strict: earlier index keeps ties
        best_dist <= score;
        best_idx  <= cur_idx;
      end
    end
  end
endmodule

// File: rtl/lev_fetch_seq.sv
module lev_fetch_seq
  import lev_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int VEC_W     = 16,
  parameter int VMAP_BASE = 'h200,
  parameter int DICT_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  output logic              char_step,
  output logic [VEC_W-1:0]  eq,
  output logic              word_end,
  output logic              done
);
  fetch_st_e         st;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        ch_q, hi_q;
  logic              got;

  assign got       = rsp_valid && rsp_ready;
  assign req_valid = (st == S_REQ_CH) || (st == S_REQ_HI) || (st == S_REQ_LO);
  assign rsp_ready = (st == S_WAIT_CH) || (st == S_WAIT_HI) || (st == S_WAIT_LO);
  assign eq        = VEC_W'({hi_q, rsp_data});
  assign char_step = got && (st == S_WAIT_LO);
  assign word_end  = got && (st == S_WAIT_CH) && (rsp_data == WORD_END_BYTE);
  assign done      = got && (st == S_WAIT_CH) && (rsp_data == LIST_END_BYTE);

  always_comb begin
    case (st)
      S_REQ_HI: req_addr = ADDR_W'(VMAP_BASE) + ADDR_W'({ch_q, 1'b0});
      S_REQ_LO: req_addr = ADDR_W'(VMAP_BASE) + ADDR_W'({ch_q, 1'b1});
      default:  req_addr = ADDR_W'(DICT_BASE) + ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ptr  <= '0;
      ch_q <= '0;
      hi_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ptr <= '0;
          st  <= S_REQ_CH;
        end
        S_REQ_CH: if (req_ready) st <= S_WAIT_CH;
        S_WAIT_CH: if (got) begin
          if (rsp_data == LIST_END_BYTE) st <= S_IDLE;
          else begin
            ptr  <= ptr + ADDR_W'(1);
            ch_q <= rsp_data;
            st   <= (rsp_data == WORD_END_BYTE) ? S_REQ_CH : S_REQ_HI;
          end
        end
        S_REQ_HI: if (req_ready) st <= S_WAIT_HI;
        S_WAIT_HI: if (got) begin
          hi_q <= rsp_data;
          st   <= S_REQ_LO;
        end
        S_REQ_LO: if (req_ready) st <= S_WAIT_LO;
        S_WAIT_LO: if (got) st <= S_REQ_CH;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lev_search_top.sv
module lev_search_top #(
  parameter int ADDR_W    = 23,
  parameter int VEC_W     = 16,
  parameter int IDX_W     = 16,
  parameter int SCORE_W   = 8,
  parameter int VMAP_BASE = 'h200,
  parameter int DICT_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data
);
  localparam int LW = $clog2(VEC_W);

  logic               run, start, done, char_step, word_end;
  logic [7:0]         len_q;
  logic [VEC_W-1:0]   eq;
  logic [SCORE_W-1:0] score, best_dist;
  logic [IDX_W-1:0]   best_idx;

  assign start = reg_we && (reg_addr == 3'd0) && reg_wdata[0] && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      len_q <= '0;
    end else begin
      if (start)     run <= 1'b1;
      else if (done) run <= 1'b0;
      if (reg_we && reg_addr == 3'd2) len_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {7'd0, run};
      3'd2:    reg_rdata = len_q;
      3'd3:    reg_rdata = 8'(VEC_W - 1);
      3'd4:    reg_rdata = 8'(best_idx >> 8);
      3'd5:    reg_rdata = 8'(best_idx);
      3'd6:    reg_rdata = 8'(best_dist);
      default: reg_rdata = 8'h00;
    endcase
  end

  lev_fetch_seq #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VMAP_BASE(VMAP_BASE), .DICT_BASE(DICT_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready), .rsp_data(mem_rsp_data),
    .char_step(char_step), .eq(eq), .word_end(word_end), .done(done)
  );

  lev_bv_core #(.VEC_W(VEC_W), .SCORE_W(SCORE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .init(start || word_end), .step(char_step),
    .eq(eq), .len_m1(len_q[LW-1:0]), .score(score)
  );

  lev_best_track #(.IDX_W(IDX_W), .SCORE_W(SCORE_W)) u_best (
    .clk(clk), .rst_n(rst_n), .start(start), .word_end(word_end),
    .score(score), .best_idx(best_idx), .best_dist(best_dist)
  );
endmodule

// File: rtl/lev_search_chk.sv
module lev_search_chk #(
  parameter int ADDR_W    = 23,
  parameter int SCORE_W   = 8,
  parameter int VMAP_BASE = 'h200,
  parameter int DICT_BASE = 'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [SCORE_W-1:0] best_dist
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_req_valid);

  // R4 and R5: vector table or word list only
  p_addr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr >= ADDR_W'(DICT_BASE) ||
      (mem_req_addr >= ADDR_W'(VMAP_BASE) && mem_req_addr < ADDR_W'(VMAP_BASE + 512))));

  p_best_nonincr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (best_dist <= $past(best_dist)));
endmodule

bind lev_search_top lev_search_chk #(
  .ADDR_W(ADDR_W), .SCORE_W(SCORE_W), .VMAP_BASE(VMAP_BASE), .DICT_BASE(DICT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .best_dist(best_dist)
);

// File: tb/sim_lev_search_top.sv
module sim_lev_search_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_req_valid, mem_rsp_ready;
  logic        mem_req_ready = 1'b0;
  logic [22:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lev_search_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  // memory model with stalls on both sides
  logic [7:0]  vmem [0:511];
  logic [7:0]  dmem [0:2047];
  int          cyc = 0;
  int          bad_addr = 0;
  int          req_count = 0;
  logic        pend = 1'b0;
  logic [22:0] paddr = '0;
  int          delay = 0;

  function automatic logic [7:0] fetch(logic [22:0] a);
    if (a >= 23'h200 && a < 23'h400) return vmem[a - 23'h200];
    if (a >= 23'h400 && a < 23'h400 + 23'd2048) return dmem[a - 23'h400];
    return 8'h01;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      pend      <= 1'b1;
      paddr     <= mem_req_addr;
      delay     <= cyc % 3;
      req_count <= req_count + 1;
      if (!((mem_req_addr >= 23'h200 && mem_req_addr < 23'h400) ||
            (mem_req_addr >= 23'h400 && mem_req_addr < 23'h400 + 23'd2048)))
        bad_addr <= bad_addr + 1;
    end else if (pend && !mem_rsp_valid) begin
      if (delay == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= fetch(paddr);
        pend          <= 1'b0;
      end else delay <= delay - 1;
    end
    mem_req_ready <= ((cyc % 4) != 1) && !pend && !mem_rsp_valid &&
                     !(mem_req_valid && mem_req_ready);
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int lev_ref(string a, string b);
    int row [0:300];
    int diag, tmp;
    for (int j = 0; j <= b.len(); j++) row[j] = j;
    for (int i = 1; i <= a.len(); i++) begin
      diag = row[0];
      row[0] = i;
      for (int j = 1; j <= b.len(); j++) begin
        tmp = row[j];
        row[j] = diag + ((a[i-1] == b[j-1]) ? 0 : 1);
        if (row[j-1] + 1 < row[j]) row[j] = row[j-1] + 1;
        if (tmp + 1 < row[j]) row[j] = tmp + 1;
        diag = tmp;
      end
    end
    return row[b.len()];
  endfunction

  task automatic run_search(string tag, string pat, string words[$]);
    int p = 0;
    int best = 255, bidx = 0, d;
    int bad0;
    logic [7:0] v, hi, lo;
    for (int i = 0; i < 512; i++) vmem[i] = 8'h00;
    for (int i = 0; i < pat.len(); i++) begin
      int c = int'(pat[i]);
      logic [15:0] vec = {vmem[2*c], vmem[2*c+1]};
      vec[i] = 1'b1;
      vmem[2*c] = vec[15:8];
      vmem[2*c+1] = vec[7:0];
    end
    foreach (words[k]) begin
      for (int i = 0; i < words[k].len(); i++) begin dmem[p] = words[k][i]; p++; end
      dmem[p] = 8'h00; p++;
      d = lev_ref(pat, words[k]);
      if (d < best) begin best = d; bidx = k; end
    end
    dmem[p] = 8'h01;
    bad0 = bad_addr;
    wr(3'd2, 8'(pat.len() - 1));
    rd(3'd2, v);
    check({tag, " R2 length reg"}, v, pat.len() - 1);
    wr(3'd0, 8'h01);
    rd(3'd0, v);
    check({tag, " R3 busy while searching"}, v, 1);
    for (int t = 0; t < 60000; t++) begin
      rd(3'd0, v);
      if (v[0] == 1'b0) break;
    end
    check({tag, " R3 enable cleared at end"}, v, 0);
    rd(3'd4, hi);
    rd(3'd5, lo);
    rd(3'd6, v);
    check({tag, " R6 R7 distance"}, v, best);
    check({tag, " R7 R8 index"}, {hi, lo}, bidx);
    check({tag, " R4 R5 address legality"}, bad_addr - bad0, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd4, v); check("R1 index hi", v, 0);
    rd(3'd5, v); check("R1 index lo", v, 0);
    rd(3'd6, v); check("R1 distance", v, 255);
    rd(3'd3, v); check("R2 max length", v, 15);
  endtask

  task automatic t_no_start();
    logic [7:0] v;
    int r0 = req_count;
    wr(3'd0, 8'hFE);
    repeat (20) @(negedge clk);
    rd(3'd0, v);
    check("R3 zero bit0 no start", v, 0);
    check("R3 zero bit0 no request", req_count - r0, 0);
  endtask

  task automatic t_basic();
    run_search("basic", "application",
               '{"apple", "application", "aplication", "xyz"});
    run_search("near", "kitten", '{"sitting", "mitten", "kitchen"});
  endtask

  task automatic t_tie();
    run_search("tie R7", "car", '{"bat", "cat", "cab", "car"});
  endtask

  task automatic t_bounds();
    run_search("len16 R6", "abcdefghijklmnop",
               '{"bcdefghijklmnopq", "abcdefghijklmnoq", "ponmlkjihgfedcba"});
    run_search("len1 R6", "a", '{"bb", "ba", "a"});
  endtask

  task automatic t_empty();
    run_search("empty R10", "abc", '{"xyzw", "", "qqqqq"});
  endtask

  task automatic t_wide_index();
    string ws[$];
    for (int i = 0; i < 300; i++) ws.push_back((i == 260) ? "rotor" : "qq");
    run_search("wide R8", "motor", ws);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_start();
    t_basic();
    t_tie();
    t_bounds();
    t_empty();
    t_wide_index();
    finish_run();
  end
endmodule